// File: doc/BRIEF.md
# Accumulator-Link Operate Unit

This unit carries out one register-operate instruction on a 12-bit accumulator (AC) and a single link flag. The caller presents a 12-bit instruction word with the current accumulator and link values, and raises `start` for one clock. One clock later the unit raises `done` for one cycle and shows the new accumulator and link values on its outputs. These values stay there until the next `start`.

Each enable bit in the word selects one micro-step: clear AC, clear link, complement AC, complement link, increment AC, rotate right, rotate left, and a doubling bit that turns a single rotate into a two-place rotate. The unit always applies the selected steps in the same order: clears, then complements, then the increment, then the rotate. Because of this order, a single word can form useful constants, compute a negation, or move the link into the accumulator. The unit checks that the word belongs to this operate group. A word outside the group passes the accumulator and link through unchanged.

Top module: `acl_operate_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge clears `ac_out`, `link_out` and `done` to 0.
- R2: `done` is 1 in exactly the cycle after a cycle with `start` high, and 0 otherwise. When `start` is low, `ac_out` and `link_out` keep their values.
- R3: A word is in the group only when bits [11:9] equal 3'b111 and bit 8 is 0. For any other word, the outputs after `start` equal the `ac_in` and `link_in` values presented with it. Word 12'o7000 also leaves both values unchanged.
- R4: Bit 7 (octal weight 0200) clears the AC and bit 6 (0100) clears the link. Both clears act before any other step.
- R5: Bit 5 (0040) replaces the AC with its one's complement and bit 4 (0020) inverts the link. Both act after the clears, so 12'o7240 gives AC 12'o7777 and 12'o7120 gives link 1.
- R6: Bit 0 (0001) adds one to the AC modulo 4096 after the complements, so 12'o7041 negates the AC. A carry out of AC bit 11 toggles the link instead of setting it.
- R7: Bit 3 (0010) rotates the 13-bit ring {link, AC[11:0]} right by one place: AC[0] goes to the link and the link goes to AC[11].
- R8: Bit 2 (0004) rotates the same ring left by one place: AC[11] goes to the link and the link goes to AC[0].
- R9: Bit 1 (0002) together with exactly one direction bit rotates by two places, which equals two single rotates. With no direction bit set, bit 1 has no effect.
- R10: The rotate acts last, on the result of the clears, complements and increment. For example, 12'o7204 leaves the old link in AC[0] with all other AC bits and the link at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to execute `instr` |
| instr | input | 12 | Instruction word |
| ac_in | input | 12 | Accumulator value before the instruction |
| link_in | input | 1 | Link value before the instruction |
| ac_out | output | 12 | Accumulator value after the instruction |
| link_out | output | 1 | Link value after the instruction |
| done | output | 1 | Pulses one cycle after `start` |

## Verification
Directed words cover each ordering pair:
- 7240 and 7120 catch a clear/complement swap.
- 7041 catches a complement/increment swap.
- 7204 catches a clear/rotate swap.
- An increment on 7777, with the link at both values, separates toggling the link from setting it.

Single and double rotates in both directions use AC patterns with distinct end bits. These show whether the link enters and leaves the ring at the correct end. Words with the wrong top bits, with bit 8 set, or equal to 7000 test membership decoding. Random words from this group, on random AC and link values and with both direction bits never set together, mix the steps in many combinations. A bench function checks each one.

// File: rtl/acl_pkg.sv
// Package: shared widths, field positions and the decoded-step record
// for the accumulator-link operate unit.
package acl_pkg;
    localparam int AC_W   = 12;
    localparam int WORD_W = 12;
    localparam int RING_W = AC_W + 1;

    // Bit positions of the step enables inside the instruction word.
    localparam int B_CLR_AC   = 7;
    localparam int B_CLR_LK   = 6;
    localparam int B_CMP_AC   = 5;
    localparam int B_CMP_LK   = 4;
    localparam int B_ROT_R    = 3;
    localparam int B_ROT_L    = 2;
    localparam int B_DOUBLE   = 1;
    localparam int B_INC      = 0;
    localparam int B_GROUPSEL = 8;

    // Decoded step enables, valid only when member is set.
    typedef struct packed {
        logic member;
        logic clr_ac;
        logic clr_lk;
        logic cmp_ac;
        logic cmp_lk;
        logic inc;
        logic rot_r;
        logic rot_l;
        logic twice;
    } acl_steps_t;
endpackage

// File: rtl/acl_decode.sv
// Module: acl_decode
// Splits an instruction word into the step enables. Assumes the
// opcode field is the top three bits and that bit 8 chooses this
// operate group when 0. Every enable is forced off for non-members.
module acl_decode
    import acl_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output acl_steps_t        steps
);
    localparam logic [2:0] OPC_OPERATE = 3'b111;

    logic is_member;

    // Membership test on opcode field and group select bit.
    always_comb begin
        is_member = (instr[WORD_W-1:WORD_W-3] == OPC_OPERATE) && !instr[B_GROUPSEL];
    end

    // Gate every enable with membership.
    always_comb begin
        steps.member = is_member;
        steps.clr_ac = is_member & instr[B_CLR_AC];
        steps.clr_lk = is_member & instr[B_CLR_LK];
        steps.cmp_ac = is_member & instr[B_CMP_AC];
        steps.cmp_lk = is_member & instr[B_CMP_LK];
        steps.inc    = is_member & instr[B_INC];
        steps.rot_r  = is_member & instr[B_ROT_R];
        steps.rot_l  = is_member & instr[B_ROT_L];
        steps.twice  = is_member & instr[B_DOUBLE];
    end
endmodule

// File: rtl/acl_arith.sv
// Module: acl_arith
// Runs the clear, complement and increment steps in that order and
// produces the 13-bit ring {link, ac} that the rotate stage consumes.
// Assumes enables are already gated by membership.
module acl_arith
    import acl_pkg::*;
#(
    parameter int W = AC_W
) (
    input  logic         clr_ac,
    input  logic         clr_lk,
    input  logic         cmp_ac,
    input  logic         cmp_lk,
    input  logic         inc,
    input  logic [W-1:0] ac_in,
    input  logic         link_in,
    output logic [W:0]   ring_out
);
    logic [W-1:0] ac_clr, ac_cmp;
    logic         lk_clr, lk_cmp;
    logic [W:0]   sum;
    logic [W-1:0] ac_inc;
    logic         lk_inc;

    // Step 1: clears.
    always_comb begin
        ac_clr = clr_ac ? '0 : ac_in;
        lk_clr = clr_lk ? 1'b0 : link_in;
    end

    // Step 2: complements act on the cleared values.
    always_comb begin
        ac_cmp = cmp_ac ? ~ac_clr : ac_clr;
        lk_cmp = cmp_lk ? ~lk_clr : lk_clr;
    end

    // Step 3: increment; carry out of the MSB toggles the link.
    always_comb begin
        sum    = {1'b0, ac_cmp} + {{W{1'b0}}, inc};
        ac_inc = sum[W-1:0];
        lk_inc = lk_cmp ^ sum[W];
    end

    // Pack the ring with the link above the accumulator MSB.
    always_comb begin
        ring_out = {lk_inc, ac_inc};
    end
endmodule

// File: rtl/acl_rotate.sv
// Module: acl_rotate
// Rotates the {link, ac} ring by one or two places. Built as a chain of
// single-place stages; stage 0 runs for any rotate, later stages only
// when the doubling bit is set. Both direction bits set: no rotation.
module acl_rotate #(
    parameter int RW    = 13,
    parameter int STAGES = 2
) (
    input  logic          rot_r,
    input  logic          rot_l,
    input  logic          twice,
    input  logic [RW-1:0] ring_in,
    output logic [RW-1:0] ring_out
);
    logic [RW-1:0] chain [STAGES+1];
    logic          go_r, go_l;

    // Resolve direction; conflicting bits rotate nothing.
    always_comb begin
        go_r = rot_r & ~rot_l;
        go_l = rot_l & ~rot_r;
    end

    // Feed the chain.
    always_comb begin
        chain[0] = ring_in;
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic active;
        // One-place stage, active on first stage or when doubling.
        always_comb begin
            active = (k == 0) ? 1'b1 : twice;
            if (active && go_r)
                chain[k+1] = {chain[k][0], chain[k][RW-1:1]};
            else if (active && go_l)
                chain[k+1] = {chain[k][RW-2:0], chain[k][RW-1]};
            else
                chain[k+1] = chain[k];
        end
    end

    // Drive the result from the end of the chain.
    always_comb begin
        ring_out = chain[STAGES];
    end
endmodule

// File: rtl/acl_operate_unit.sv
// Module: acl_operate_unit
// Top of the accumulator-link operate unit. On start it decodes the
// word, runs the combinational step chain and registers the result;
// done pulses one clock after start. Assumes start is a single-cycle
// strobe. Non-member words pass ac_in/link_in through unchanged.
module acl_operate_unit
    import acl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic [AC_W-1:0]   ac_in,
    input  logic              link_in,
    output logic [AC_W-1:0]   ac_out,
    output logic              link_out,
    output logic              done
);
    acl_steps_t        steps;
    logic [RING_W-1:0] ring_mid;
    logic [RING_W-1:0] ring_fin;

    acl_decode u_decode (
        .instr (instr),
        .steps (steps)
    );

    acl_arith #(.W(AC_W)) u_arith (
        .clr_ac   (steps.clr_ac),
        .clr_lk   (steps.clr_lk),
        .cmp_ac   (steps.cmp_ac),
        .cmp_lk   (steps.cmp_lk),
        .inc      (steps.inc),
        .ac_in    (ac_in),
        .link_in  (link_in),
        .ring_out (ring_mid)
    );

    acl_rotate #(.RW(RING_W), .STAGES(2)) u_rotate (
        .rot_r    (steps.rot_r),
        .rot_l    (steps.rot_l),
        .twice    (steps.twice),
        .ring_in  (ring_mid),
        .ring_out (ring_fin)
    );

    // Result register: capture on start, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_out   <= '0;
            link_out <= 1'b0;
        end else if (start) begin
            ac_out   <= ring_fin[AC_W-1:0];
            link_out <= ring_fin[AC_W];
        end
    end

    // Completion strobe, one clock behind start.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= start;
    end

    // Guards on the registered interface.
    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R2
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start)); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(ac_out) && $stable(link_out))); // R2
    AST_FOREIGN_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !steps.member) |=> (ac_out == $past(ac_in) && link_out == $past(link_in))); // R3
    AST_CLEAR_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && instr == 12'o7240) |=> (ac_out == 12'o7777)); // R5
    AST_SINGLE_RIGHT_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (start && instr == 12'o7010) |=> (link_out == $past(ac_in[0]) && ac_out[AC_W-1] == $past(link_in))); // R7
endmodule

// File: tb/tb_acl_operate_unit.sv
module tb_acl_operate_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] ac_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] ac_out;
    logic        link_out;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    acl_operate_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .ac_in(ac_in), .link_in(link_in),
        .ac_out(ac_out), .link_out(link_out), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: returns {link, ac} from the requirement text.
    function automatic logic [12:0] model(input logic [11:0] w,
                                          input logic [11:0] a,
                                          input logic l);
        logic [12:0] r;
        logic [12:0] s;
        int n;
        if (w[11:9] != 3'b111 || w[8]) return {l, a};
        if (w[7]) a = '0;
        if (w[6]) l = 1'b0;
        if (w[5]) a = ~a;
        if (w[4]) l = ~l;
        if (w[0]) begin
            s = {1'b0, a} + 13'd1;
            a = s[11:0];
            if (s[12]) l = ~l;
        end
        r = {l, a};
        n = w[1] ? 2 : 1;
        for (int k = 0; k < n; k++) begin
            if (w[3] && !w[2]) r = {r[0], r[12:1]};
            if (w[2] && !w[3]) r = {r[11:0], r[12]};
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%o expected=%o", tag, act, exp);
        end
    endtask

    // Issue one instruction and check the done pulse, result and hold.
    task automatic run_op(input string tag, input logic [11:0] w,
                          input logic [11:0] a, input logic l);
        logic [12:0] exp;
        exp = model(w, a, l);
        @(negedge clk);
        instr = w; ac_in = a; link_in = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ac_in = ~a; link_in = ~l;
        check({tag, " done"}, {31'd0, done}, 32'd1);
        check(tag, {19'd0, link_out, ac_out}, {19'd0, exp});
        @(negedge clk);
        check("R2 done low", {31'd0, done}, 32'd0);
        check("R2 hold", {19'd0, link_out, ac_out}, {19'd0, exp});
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [11:0] w;
        int seed;
        seed = 1234;
        void'($urandom(seed));
        rst_n = 1'b0;
        start = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ac", {20'd0, ac_out}, 32'd0);
        check("R1 link", {31'd0, link_out}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        run_op("R3 nop", 12'o7000, 12'o1234, 1'b1);
        run_op("R3 bit8", 12'o7400, 12'o5555, 1'b0);
        run_op("R3 opcode", 12'o6001, 12'o0707, 1'b1);
        run_op("R3 other", 12'o1377, 12'o4321, 1'b0);
        run_op("R4 cla", 12'o7200, 12'o7070, 1'b1);
        run_op("R4 cll", 12'o7100, 12'o7070, 1'b1);
        run_op("R5 set ac", 12'o7240, 12'o1234, 1'b0);
        run_op("R5 set link", 12'o7120, 12'o1234, 1'b0);
        run_op("R5 cml", 12'o7020, 12'o0001, 1'b1);
        run_op("R6 negate", 12'o7041, 12'o0005, 1'b0);
        run_op("R6 wrap l0", 12'o7001, 12'o7777, 1'b0);
        run_op("R6 wrap l1", 12'o7001, 12'o7777, 1'b1);
        run_op("R7 rar", 12'o7010, 12'o4001, 1'b0);
        run_op("R7 rar link", 12'o7010, 12'o0002, 1'b1);
        run_op("R8 ral", 12'o7004, 12'o4001, 1'b0);
        run_op("R8 ral link", 12'o7004, 12'o2000, 1'b1);
        run_op("R9 rtr", 12'o7012, 12'o0003, 1'b1);
        run_op("R9 rtl", 12'o7006, 12'o6000, 1'b1);
        run_op("R9 alone", 12'o7002, 12'o1357, 1'b1);
        run_op("R10 glk1", 12'o7204, 12'o7777, 1'b1);
        run_op("R10 glk0", 12'o7204, 12'o7777, 1'b0);
        run_op("R10 cia rot", 12'o7051, 12'o0001, 1'b0);

        for (int i = 0; i < 400; i++) begin
            w = {4'b1110, 8'($urandom)};
            if (w[3] && w[2]) w[2] = 1'b0;
            run_op("R10 random", w, 12'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule